// File: doc/BRIEF.md
# Parasitic-Power Strong Pull-Up Sequencer

This block sits beside a 1-Wire bus master and drives one active-high enable for an external strong pull-up transistor. Devices on the bus that draw power from the data line need extra current while the line is idle-high. The block supplies that current at fixed points in the bus sequence: before and after the presence phase that follows a bus reset, and in the recovery part of every read or write slot. The master reports what it is doing through single-cycle event pulses, a level that shows when it pulls the line low, and the attributes of each slot. All timing is counted in ticks of a 1 µs strobe. A speed input picks the standard or the overdrive time set.

Before it asserts the enable, the block polls the synchronised line level once per tick. A write slot counts as high at once. The first bit of a byte ends its assertion three ticks sooner, which keeps the pull-up off for longer before the next slot. A hold mode lets the enable stay on after the last bit of a byte until the master starts the next reset or slot. The enable is always forced low while the master pulls the line low, or when support is switched off.

Top module: `ow_strong_pullup`

## Requirements
- R1: After reset, and while no bus event has been seen, `spu_o` is 0.
- R2: When the master releases a bus reset (falling edge of `mst_low_i` after `rst_begin_i`), the enable stays low for 499 ticks in standard speed (`ovd_i`=0) or 39 ticks in overdrive (`ovd_i`=1). It then asserts at the first tick that finds `line_hi_i` high, for 8 ticks (standard) or 1 tick (overdrive). Ticks from the release to the rising edge, including the polling tick, are 500 or 40.
- R3: After presence support ends, the enable stays low for one tick. It then polls the line and asserts for 10 ticks at either speed. The whole reset sequence gives exactly two assertions.
- R4: In a write slot (`slot_wr_i`=1), the enable asserts in the cycle after the master release, with no polling. It stays on for 64 ticks (bit 1) or 8 ticks (bit 0) at standard speed, and 9 ticks (bit 1) or 1 tick (bit 0) in overdrive.
- R5: In a read slot (`slot_wr_i`=0), the enable asserts at the first polled tick with the line high. It stays on for the same number of ticks as a write slot with the same `slot_bit_i`.
- R6: The enable never asserts while the polled line level is low, however long the line stays low.
- R7: When `slot_first_i` was 1 at slot start, the on-time is 3 ticks shorter than the R4 value, but never less than 1 tick.
- R8: After a slot marked `slot_last_i`=1 finishes its on-time, `hold_mode_i`=1 keeps the enable high until the next `rst_begin_i` or `slot_begin_i`. With `hold_mode_i`=0 the enable drops after the normal on-time.
- R9: A pulse on `rst_begin_i` or `slot_begin_i` brings `spu_o` to 0 in the following cycle and aborts any sequence in progress.
- R10: `spu_o` is 0 in every cycle in which `mst_low_i` is 1. An on-time that is still running resumes when `mst_low_i` returns to 0.
- R11: With `spu_en_i`=0, `spu_o` stays 0 and bus events start no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe every 1 µs |
| ovd_i | input | 1 | 1 = overdrive time set, 0 = standard |
| spu_en_i | input | 1 | Strong pull-up support enable |
| hold_mode_i | input | 1 | 1 = keep enable on after last bit of a byte |
| rst_begin_i | input | 1 | Pulse: master starts a bus reset |
| slot_begin_i | input | 1 | Pulse: master starts a time slot |
| slot_bit_i | input | 1 | Bit value of the starting slot |
| slot_wr_i | input | 1 | 1 = write slot, 0 = read slot |
| slot_first_i | input | 1 | Starting slot carries the first bit of a byte |
| slot_last_i | input | 1 | Starting slot carries the last bit of a byte |
| mst_low_i | input | 1 | Master is pulling the line low |
| line_hi_i | input | 1 | Synchronised bus line level |
| spu_o | output | 1 | Strong pull-up enable |

## Verification
The hardest state to reach from the ports is a polling phase that waits on a line held low by something other than the master. Examples are a read slot or the presence recovery while a device pulls the bus down. To get there, the stimulus releases the master's drive and then holds `line_hi_i` low for many ticks. It checks that the enable stays off and that no ticks of the on-time are used up. Only after that does the line rise, and the stimulus measures the full on-time. Every release is placed in a cycle with no tick, so the tick counts seen at the output do not depend on phase.

// File: rtl/spu_pkg.sv
package spu_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_PD_WAIT,
    ST_PD_POLL,
    ST_PD_ON,
    ST_PR_WAIT,
    ST_PR_POLL,
    ST_PR_ON,
    ST_SL_LOW,
    ST_SL_POLL,
    ST_SL_ON,
    ST_HOLD
  } spu_state_e;

  typedef struct packed {
    logic bit_val;
    logic is_wr;
    logic first;
    logic last;
  } slot_attr_t;

  function automatic logic state_drives(spu_state_e s);
    return (s == ST_PD_ON) || (s == ST_PR_ON) || (s == ST_SL_ON) || (s == ST_HOLD);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spu_tick_timer.sv
module spu_tick_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          tick_i,
  output logic          expire_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_ce = 1'b1;
      cnt_d  = val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  // the tick that takes the count from one to zero ends the interval
  assign expire_o = tick_i && (cnt_q == CW'(1));

endmodule

// File: rtl/spu_evt.sv
module spu_evt
  import spu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mst_low_i,
  input  logic       slot_begin_i,
  input  slot_attr_t attr_i,
  output logic       release_o,
  output slot_attr_t attr_o
);

  logic       mst_q;
  slot_attr_t attr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= 1'b0;
    end else begin
      mst_q <= mst_low_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
    end else if (slot_begin_i) begin
      attr_q <= attr_i;
    end
  end

  assign release_o = mst_q && !mst_low_i;
  assign attr_o    = attr_q;

endmodule

// File: rtl/spu_seq.sv
module spu_seq
  import spu_pkg::*;
#(
  parameter int CW          = 9,
  parameter int DLY_PD_STD  = 499,
  parameter int DLY_PD_OVD  = 39,
  parameter int ON_PD_STD   = 8,
  parameter int ON_PD_OVD   = 1,
  parameter int DLY_PR      = 1,
  parameter int ON_PR       = 10,
  parameter int ON_W1_STD   = 64,
  parameter int ON_W1_OVD   = 9,
  parameter int ON_W0_STD   = 8,
  parameter int ON_W0_OVD   = 1,
  parameter int FIRST_EXTRA = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          ovd_i,
  input  logic          hold_i,
  input  logic          rst_begin_i,
  input  logic          slot_begin_i,
  input  logic          release_i,
  input  logic          tick_i,
  input  logic          line_hi_i,
  input  slot_attr_t    attr_i,
  input  logic          expire_i,
  output logic          load_o,
  output logic [CW-1:0] val_o,
  output logic          on_o
);

  spu_state_e state_q;
  spu_state_e state_d;

  int base_len;
  int slot_len;
  int pd_dly;
  int pd_on;

  always_comb begin
    pd_dly = ovd_i ? DLY_PD_OVD : DLY_PD_STD;
    pd_on  = ovd_i ? ON_PD_OVD  : ON_PD_STD;
    if (attr_i.bit_val) begin
      base_len = ovd_i ? ON_W1_OVD : ON_W1_STD;
    end else begin
      base_len = ovd_i ? ON_W0_OVD : ON_W0_STD;
    end
    if (!attr_i.first) begin
      slot_len = base_len;
    end else if (base_len > FIRST_EXTRA) begin
      slot_len = base_len - FIRST_EXTRA;
    end else begin
      slot_len = 1;
    end
  end

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    val_o   = '0;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else if (rst_begin_i) begin
      state_d = ST_RST_LOW;
    end else if (slot_begin_i) begin
      state_d = ST_SL_LOW;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_RST_LOW: begin
          if (release_i) begin
            state_d = ST_PD_WAIT;
            load_o  = 1'b1;
            val_o   = CW'(pd_dly);
          end
        end
        ST_PD_WAIT: begin
          if (expire_i) state_d = ST_PD_POLL;
        end
        ST_PD_POLL: begin
          if (tick_i && line_hi_i) begin
            state_d = ST_PD_ON;
            load_o  = 1'b1;
            val_o   = CW'(pd_on);
          end
        end
        ST_PD_ON: begin
          if (expire_i) begin
            state_d = ST_PR_WAIT;
            load_o  = 1'b1;
            val_o   = CW'(DLY_PR);
          end
        end
        ST_PR_WAIT: begin
          if (expire_i) state_d = ST_PR_POLL;
        end
        ST_PR_POLL: begin
          if (tick_i && line_hi_i) begin
            state_d = ST_PR_ON;
            load_o  = 1'b1;
            val_o   = CW'(ON_PR);
          end
        end
        ST_PR_ON: begin
          if (expire_i) state_d = ST_IDLE;
        end
        ST_SL_LOW: begin
          if (release_i) begin
            if (attr_i.is_wr) begin
              state_d = ST_SL_ON;
              load_o  = 1'b1;
              val_o   = CW'(slot_len);
            end else begin
              state_d = ST_SL_POLL;
            end
          end
        end
        ST_SL_POLL: begin
          if (tick_i && line_hi_i) begin
            state_d = ST_SL_ON;
            load_o  = 1'b1;
            val_o   = CW'(slot_len);
          end
        end
        ST_SL_ON: begin
          if (expire_i) begin
            state_d = (attr_i.last && hold_i) ? ST_HOLD : ST_IDLE;
          end
        end
        ST_HOLD: state_d = ST_HOLD;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign on_o = state_drives(state_q);

endmodule

// File: rtl/ow_strong_pullup.sv
module ow_strong_pullup
  import spu_pkg::*;
#(
  parameter int DLY_PD_STD  = 499,
  parameter int DLY_PD_OVD  = 39,
  parameter int ON_PD_STD   = 8,
  parameter int ON_PD_OVD   = 1,
  parameter int DLY_PR      = 1,
  parameter int ON_PR       = 10,
  parameter int ON_W1_STD   = 64,
  parameter int ON_W1_OVD   = 9,
  parameter int ON_W0_STD   = 8,
  parameter int ON_W0_OVD   = 1,
  parameter int FIRST_EXTRA = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ovd_i,
  input  logic spu_en_i,
  input  logic hold_mode_i,
  input  logic rst_begin_i,
  input  logic slot_begin_i,
  input  logic slot_bit_i,
  input  logic slot_wr_i,
  input  logic slot_first_i,
  input  logic slot_last_i,
  input  logic mst_low_i,
  input  logic line_hi_i,
  output logic spu_o
);

  localparam int MAX_A = imax(imax(DLY_PD_STD, DLY_PD_OVD), imax(ON_PD_STD, ON_PD_OVD));
  localparam int MAX_B = imax(imax(DLY_PR, ON_PR), imax(ON_W1_STD, ON_W1_OVD));
  localparam int MAX_C = imax(ON_W0_STD, ON_W0_OVD);
  localparam int MAX_V = imax(imax(MAX_A, MAX_B), MAX_C);
  localparam int CW    = $clog2(MAX_V + 1);

  logic rst_meta_n;
  logic rst_sync_n;

  // reset asserts at once and leaves two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  slot_attr_t    attr_in;
  slot_attr_t    attr_q;
  logic          release_w;
  logic          load_w;
  logic [CW-1:0] val_w;
  logic          expire_w;
  logic          on_w;

  assign attr_in = '{bit_val: slot_bit_i, is_wr: slot_wr_i,
                     first: slot_first_i, last: slot_last_i};

  spu_evt evt_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mst_low_i    (mst_low_i),
    .slot_begin_i (slot_begin_i),
    .attr_i       (attr_in),
    .release_o    (release_w),
    .attr_o       (attr_q)
  );

  spu_tick_timer #(.CW(CW)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (load_w),
    .val_i    (val_w),
    .tick_i   (tick_i),
    .expire_o (expire_w)
  );

  spu_seq #(
    .CW(CW), .DLY_PD_STD(DLY_PD_STD), .DLY_PD_OVD(DLY_PD_OVD),
    .ON_PD_STD(ON_PD_STD), .ON_PD_OVD(ON_PD_OVD), .DLY_PR(DLY_PR), .ON_PR(ON_PR),
    .ON_W1_STD(ON_W1_STD), .ON_W1_OVD(ON_W1_OVD), .ON_W0_STD(ON_W0_STD),
    .ON_W0_OVD(ON_W0_OVD), .FIRST_EXTRA(FIRST_EXTRA)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .en_i         (spu_en_i),
    .ovd_i        (ovd_i),
    .hold_i       (hold_mode_i),
    .rst_begin_i  (rst_begin_i),
    .slot_begin_i (slot_begin_i),
    .release_i    (release_w),
    .tick_i       (tick_i),
    .line_hi_i    (line_hi_i),
    .attr_i       (attr_q),
    .expire_i     (expire_w),
    .load_o       (load_w),
    .val_o        (val_w),
    .on_o         (on_w)
  );

  // the master's pull-down always wins over the pull-up
  assign spu_o = on_w && spu_en_i && !mst_low_i;

endmodule

// File: rtl/spu_chk.sv
module spu_chk #(
  parameter int MAX_ON = 64
) (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic spu_en_i,
  input logic hold_mode_i,
  input logic rst_begin_i,
  input logic slot_begin_i,
  input logic mst_low_i,
  input logic spu_o
);

  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
    end else if (!spu_o) begin
      run_q <= 0;
    end else if (tick_i) begin
      run_q <= run_q + 1;
    end
  end

  assert_force_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mst_low_i |-> !spu_o);

  assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !spu_en_i |-> !spu_o);

  assert_slot_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_begin_i |=> !spu_o);

  assert_reset_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_begin_i |=> !spu_o);

  assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spu_o) |-> ($past(tick_i) || $past(mst_low_i) || $past(mst_low_i, 2)));

  assert_on_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_mode_i || (run_q <= MAX_ON));

endmodule

bind ow_strong_pullup spu_chk #(.MAX_ON(64)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tick_i       (tick_i),
  .spu_en_i     (spu_en_i),
  .hold_mode_i  (hold_mode_i),
  .rst_begin_i  (rst_begin_i),
  .slot_begin_i (slot_begin_i),
  .mst_low_i    (mst_low_i),
  .spu_o        (spu_o)
);

// File: tb/ow_strong_pullup_tb_top.sv
`timescale 1ns/1ps
module ow_strong_pullup_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic ovd_i = 1'b0;
  logic spu_en_i = 1'b1;
  logic hold_mode_i = 1'b0;
  logic rst_begin_i = 1'b0;
  logic slot_begin_i = 1'b0;
  logic slot_bit_i = 1'b0;
  logic slot_wr_i = 1'b0;
  logic slot_first_i = 1'b0;
  logic slot_last_i = 1'b0;
  logic mst_low_i = 1'b0;
  logic line_hi_i = 1'b1;
  logic spu_o;

  int n_chk = 0;
  int n_bad = 0;
  int on_ticks = 0;
  int pre_ticks = 0;
  int rises = 0;
  bit seen_rise = 0;
  bit prev_o = 0;
  int tdiv = 0;

  always #2 clk = ~clk;

  ow_strong_pullup dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ovd_i(ovd_i), .spu_en_i(spu_en_i),
    .hold_mode_i(hold_mode_i), .rst_begin_i(rst_begin_i), .slot_begin_i(slot_begin_i),
    .slot_bit_i(slot_bit_i), .slot_wr_i(slot_wr_i), .slot_first_i(slot_first_i),
    .slot_last_i(slot_last_i), .mst_low_i(mst_low_i), .line_hi_i(line_hi_i), .spu_o(spu_o)
  );

  // 1 us strobe modelled as one cycle in four
  always @(posedge clk) begin
    #1;
    tick_i = (tdiv == 3);
    tdiv = (tdiv + 1) % 4;
  end

  always @(negedge clk) begin
    if (tick_i && spu_o) on_ticks++;
    if (tick_i && !spu_o && !seen_rise) pre_ticks++;
    if (spu_o && !prev_o) rises++;
    if (spu_o) seen_rise = 1;
    prev_o = spu_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) step();
  endtask

  task automatic clr_meas();
    on_ticks = 0; pre_ticks = 0; rises = 0; seen_rise = 0;
  endtask

  // leave the caller in a cycle that carries no tick
  task automatic align();
    step();
    while (!tick_i) step();
    step();
  endtask

  task automatic start_reset();
    rst_begin_i = 1'b1; mst_low_i = 1'b1;
    step();
    rst_begin_i = 1'b0;
    repeat (6) step();
    align();
    mst_low_i = 1'b0;
    clr_meas();
  endtask

  task automatic start_slot(input bit wr, input bit b, input bit first, input bit last);
    slot_wr_i = wr; slot_bit_i = b; slot_first_i = first; slot_last_i = last;
    slot_begin_i = 1'b1; mst_low_i = 1'b1;
    step();
    slot_begin_i = 1'b0;
    repeat (3) step();
    align();
    mst_low_i = 1'b0;
    clr_meas();
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(spu_o == 1'b0, "R1 idle after reset", int'(spu_o), 0);
    wait_ticks(5);
    @(negedge clk);
    chk(spu_o == 1'b0, "R1 idle without events", int'(spu_o), 0);
  endtask

  task automatic t_presence(input bit ovd, input int exp_pre, input int exp_on);
    ovd_i = ovd; line_hi_i = 1'b1;
    start_reset();
    wait_ticks(exp_pre + 40);
    chk(pre_ticks == exp_pre, "R2 presence delay ticks", pre_ticks, exp_pre);
    chk(on_ticks == exp_on, "R3 presence on ticks", on_ticks, exp_on);
    chk(rises == 2, "R3 presence assertion count", rises, 2);
  endtask

  task automatic t_presence_line_low();
    ovd_i = 1'b1; line_hi_i = 1'b0;
    start_reset();
    wait_ticks(70);
    chk(on_ticks == 0 && spu_o == 1'b0, "R6 held off while line low", on_ticks, 0);
    line_hi_i = 1'b1;
    wait_ticks(30);
    chk(on_ticks == 11, "R6 presence after line rises", on_ticks, 11);
  endtask

  task automatic t_slot(input bit ovd, input bit wr, input bit b, input bit first,
                        input int low_ticks, input int exp, input string req);
    ovd_i = ovd; hold_mode_i = 1'b0; line_hi_i = 1'b1;
    if (low_ticks > 0) line_hi_i = 1'b0;
    start_slot(wr, b, first, 1'b0);
    if (low_ticks > 0) begin
      wait_ticks(low_ticks);
      chk(on_ticks == 0 && spu_o == 1'b0, "R5 read slot waits for line high", on_ticks, 0);
      line_hi_i = 1'b1;
    end
    wait_ticks(exp + 8);
    chk(on_ticks == exp, req, on_ticks, exp);
  endtask

  task automatic t_hold();
    ovd_i = 1'b0; line_hi_i = 1'b1; hold_mode_i = 1'b1;
    start_slot(1'b1, 1'b1, 1'b0, 1'b1);
    wait_ticks(150);
    @(negedge clk);
    chk(spu_o == 1'b1, "R8 hold after last bit", int'(spu_o), 1);
    step();
    slot_wr_i = 1'b1; slot_bit_i = 1'b0; slot_first_i = 1'b0; slot_last_i = 1'b0;
    slot_begin_i = 1'b1;
    step();
    slot_begin_i = 1'b0;
    @(negedge clk);
    chk(spu_o == 1'b0, "R9 slot start ends hold", int'(spu_o), 0);
    mst_low_i = 1'b1;
    repeat (3) step();
    align();
    mst_low_i = 1'b0;
    clr_meas();
    wait_ticks(16);
    chk(on_ticks == 8, "R8 following slot normal", on_ticks, 8);
    hold_mode_i = 1'b0;
    start_slot(1'b1, 1'b1, 1'b0, 1'b1);
    wait_ticks(80);
    @(negedge clk);
    chk(on_ticks == 64 && spu_o == 1'b0, "R8 no hold when mode off", on_ticks, 64);
  endtask

  task automatic t_force();
    ovd_i = 1'b0; line_hi_i = 1'b1;
    start_slot(1'b1, 1'b1, 1'b0, 1'b0);
    wait_ticks(10);
    mst_low_i = 1'b1;
    @(negedge clk);
    chk(spu_o == 1'b0, "R10 master low forces off", int'(spu_o), 0);
    step();
    mst_low_i = 1'b0;
    @(negedge clk);
    chk(spu_o == 1'b1, "R10 resumes after master low", int'(spu_o), 1);
    wait_ticks(70);
  endtask

  task automatic t_abort();
    ovd_i = 1'b1; line_hi_i = 1'b1;
    start_slot(1'b1, 1'b1, 1'b0, 1'b0);
    wait_ticks(3);
    rst_begin_i = 1'b1;
    step();
    rst_begin_i = 1'b0;
    @(negedge clk);
    chk(spu_o == 1'b0, "R9 reset start aborts slot", int'(spu_o), 0);
    mst_low_i = 1'b1;
    repeat (4) step();
    align();
    mst_low_i = 1'b0;
    clr_meas();
    wait_ticks(70);
    chk(pre_ticks == 40 && on_ticks == 11, "R9 new reset sequence runs", on_ticks, 11);
  endtask

  task automatic t_disabled();
    spu_en_i = 1'b0; ovd_i = 1'b1; line_hi_i = 1'b1;
    start_slot(1'b1, 1'b1, 1'b0, 1'b0);
    wait_ticks(15);
    chk(on_ticks == 0, "R11 slot ignored when disabled", on_ticks, 0);
    start_reset();
    wait_ticks(60);
    chk(on_ticks == 0, "R11 reset ignored when disabled", on_ticks, 0);
    spu_en_i = 1'b1;
    wait_ticks(20);
    @(negedge clk);
    chk(spu_o == 1'b0, "R11 no late sequence on enable", int'(spu_o), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset_state();
    t_presence(1'b0, 500, 18);
    t_presence(1'b1, 40, 11);
    t_presence_line_low();
    t_slot(1'b0, 1'b1, 1'b1, 1'b0, 0, 64, "R4 write 1 standard");
    t_slot(1'b0, 1'b1, 1'b0, 1'b0, 0, 8,  "R4 write 0 standard");
    t_slot(1'b1, 1'b1, 1'b1, 1'b0, 0, 9,  "R4 write 1 overdrive");
    t_slot(1'b1, 1'b1, 1'b0, 1'b0, 0, 1,  "R4 write 0 overdrive");
    t_slot(1'b0, 1'b0, 1'b1, 1'b0, 12, 64, "R5 read 1 standard");
    t_slot(1'b1, 1'b0, 1'b0, 1'b0, 5, 1,  "R5 read 0 overdrive");
    t_slot(1'b0, 1'b1, 1'b1, 1'b1, 0, 61, "R7 first bit write 1 standard");
    t_slot(1'b0, 1'b1, 1'b0, 1'b1, 0, 5,  "R7 first bit write 0 standard");
    t_slot(1'b1, 1'b1, 1'b0, 1'b1, 0, 1,  "R7 first bit clamp overdrive");
    t_hold();
    t_force();
    t_abort();
    t_disabled();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule